// File: doc/BRIEF.md
# Input Level Monitor With Gain Code

This block sits at the head of a digital down-converter and watches the 14-bit two's-complement sample stream coming from the converter. Over a programmable window of valid samples it measures either the largest sample magnitude (peak mode) or the sum of squared samples (mean-power mode). At the end of each window it latches the measurement into a result register for the host to read, and it pulses a done flag for one cycle.

In the same cycle it updates a 3-bit attenuation code for an external variable-gain amplifier. Each code step stands for 6 dB, so the code spans 0 to 42 dB over its eight values. The code counts how many doublings of amplitude the measured level lies above a programmable lower threshold. In mean-power mode a doubling of amplitude is a factor of four in the measured value. If the converter flags over-range on any accepted sample of the window, the code is forced to full attenuation. The code and the register change only on the rising clock edge that completes a window.

Top module: `input_level_monitor`

## Requirements
- R1: After reset, meas_q is 0, meas_done is 0 and gain_code is 0.
- R2: A window consists of win_len+1 samples accepted with smp_valid=1. Cycles with smp_valid=0 do not count and do not affect the result or the over-range state, whatever smp_data and ovr_flag hold. win_len=0 gives a window of one sample.
- R3: With mode_mean=0 the result is the largest absolute value of the window's samples, zero-extended. The sample -8192 gives 8192.
- R4: With mode_mean=1 the result is the sum of the squares of the window's samples, with no scaling.
- R5: On the rising edge that accepts a window's last sample, meas_q takes that window's result and meas_done goes to 1 for exactly the following cycle. Otherwise meas_done is 0 and meas_q holds its value.
- R6: Without over-range, gain_code is the number of k in 1..7 for which result >= lo_thresh*2^k (mode_mean=0) or result >= lo_thresh*4^k (mode_mean=1). A result below 2*lo_thresh (peak) or 4*lo_thresh (mean) gives 0, and lo_thresh=0 gives 7.
- R7: If ovr_flag is 1 on any accepted sample of a window, including its last sample, gain_code becomes 7 for that window. The flag does not carry into the next window.
- R8: gain_code changes only on the same edge as meas_q and holds between window completions.
- R9: Each window starts from an empty accumulation. mode_mean, win_len and lo_thresh may change between windows, and the new values take effect for the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample on smp_data is accepted this cycle |
| smp_data | input | 14 | Converter sample, two's complement |
| ovr_flag | input | 1 | Converter over-range flag for this sample |
| mode_mean | input | 1 | 0 = peak magnitude, 1 = sum of squares |
| win_len | input | 8 | Window length minus one, in accepted samples |
| lo_thresh | input | 35 | Lower threshold for the gain code, in result units |
| meas_q | output | 35 | Latched measurement of the last completed window |
| meas_done | output | 1 | One-cycle pulse after each new latched measurement |
| gain_code | output | 3 | Attenuation code, 6 dB per step |

## Verification
The two functions that fall into the same cycle are window completion and over-range detection. The bench raises ovr_flag on exactly the last accepted sample of a window. The new measurement must then be latched and gain_code must read 7 on that edge. The following window, run without the flag, must return to the level-derived code. Over-range raised only during idle cycles inside a window must leave the code as the level alone dictates.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

  // magnitude of a sign-extended sample
  function automatic logic [31:0] mag_of(input logic signed [31:0] x);
    return (x < 0) ? 32'(-x) : 32'(x);
  endfunction

  // square of a sign-extended sample
  function automatic logic [63:0] square_of(input logic signed [31:0] x);
    logic signed [63:0] w;
    w = 64'(x);
    return 64'(w * w);
  endfunction

  // count of 6 dB steps the level sits above the threshold, 0..7
  function automatic logic [2:0] level_steps(input logic [63:0] lvl,
                                             input logic [63:0] thr,
                                             input logic        pow);
    logic [3:0] n;
    n = 4'd0;
    for (int k = 1; k <= 7; k++) begin
      if (lvl >= (thr << (pow ? 2 * k : k))) n = n + 4'd1;
    end
    return n[2:0];
  endfunction

endpackage

// File: rtl/lvm_window.sv
module lvm_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_last
);
  logic [WIN_W-1:0] cnt_q;

  assign win_last = smp_valid && (cnt_q >= win_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (smp_valid) cnt_q <= win_last ? '0 : cnt_q + 1'b1;
  end

  // R2
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cnt_q));

  // R9
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> (cnt_q == '0));
endmodule

// File: rtl/lvm_accum.sv
module lvm_accum #(
  parameter int SMP_W = 14,
  parameter int ACC_W = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    mode_mean,
  input  logic                    win_last,
  output logic [ACC_W-1:0]        win_result
);
  import lvm_pkg::*;

  logic [ACC_W-1:0]  acc_q;
  logic signed [31:0] smp_ext;
  logic [ACC_W-1:0]  mag_w;
  logic [ACC_W-1:0]  sq_w;

  assign smp_ext = 32'(smp_data);
  assign mag_w   = ACC_W'(mag_of(smp_ext));
  assign sq_w    = ACC_W'(square_of(smp_ext));

  always_comb begin
    if (mode_mean) win_result = acc_q + sq_w;
    else           win_result = (mag_w > acc_q) ? mag_w : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (smp_valid) acc_q <= win_last ? '0 : win_result;
  end

  // R2
  acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(acc_q));

  // R3
  peak_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mode_mean) |-> (win_result >= mag_w));

  // R9
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> (acc_q == '0));
endmodule

// File: rtl/lvm_code.sv
module lvm_code #(
  parameter int ACC_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             ovr_flag,
  input  logic             mode_mean,
  input  logic             win_last,
  input  logic [ACC_W-1:0] win_result,
  input  logic [ACC_W-1:0] lo_thresh,
  output logic [ACC_W-1:0] meas_q,
  output logic             meas_done,
  output logic [2:0]       gain_code
);
  import lvm_pkg::*;

  logic       ovr_seen_q;
  logic       ovr_any;
  logic [2:0] lvl_code;

  assign ovr_any  = ovr_seen_q | (smp_valid & ovr_flag);
  assign lvl_code = level_steps(64'(win_result), 64'(lo_thresh), mode_mean);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q     <= '0;
      meas_done  <= 1'b0;
      gain_code  <= 3'd0;
      ovr_seen_q <= 1'b0;
    end else begin
      meas_done <= win_last;
      if (win_last) begin
        meas_q     <= win_result;
        gain_code  <= ovr_any ? 3'd7 : lvl_code;
        ovr_seen_q <= 1'b0;
      end else if (smp_valid && ovr_flag) begin
        ovr_seen_q <= 1'b1;
      end
    end
  end

  // R7
  ovr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && ovr_any) |=> (gain_code == 3'd7));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> !ovr_seen_q);

  // R5
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(meas_q));

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(gain_code));
endmodule

// File: rtl/input_level_monitor.sv
module input_level_monitor #(
  parameter  int SMP_W = 14,
  parameter  int WIN_W = 8,
  localparam int ACC_W = 2 * SMP_W - 1 + WIN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    ovr_flag,
  input  logic                    mode_mean,
  input  logic [WIN_W-1:0]        win_len,
  input  logic [ACC_W-1:0]        lo_thresh,
  output logic [ACC_W-1:0]        meas_q,
  output logic                    meas_done,
  output logic [2:0]              gain_code
);
  logic             win_last;
  logic [ACC_W-1:0] win_result;

  lvm_window #(.WIN_W(WIN_W)) win_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .win_len(win_len), .win_last(win_last)
  );

  lvm_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .mode_mean(mode_mean), .win_last(win_last), .win_result(win_result)
  );

  lvm_code #(.ACC_W(ACC_W)) code_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ovr_flag(ovr_flag),
    .mode_mean(mode_mean), .win_last(win_last), .win_result(win_result),
    .lo_thresh(lo_thresh), .meas_q(meas_q), .meas_done(meas_done),
    .gain_code(gain_code)
  );

  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> meas_done);
endmodule

// File: tb/input_level_monitor_tb.sv
module input_level_monitor_tb_top;
  localparam int ACC_W = 35;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [13:0] smp_data = '0;
  logic               ovr_flag = 1'b0;
  logic               mode_mean = 1'b0;
  logic [7:0]         win_len = '0;
  logic [ACC_W-1:0]   lo_thresh = '0;
  logic [ACC_W-1:0]   meas_q;
  logic               meas_done;
  logic [2:0]         gain_code;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  input_level_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .ovr_flag(ovr_flag), .mode_mean(mode_mean), .win_len(win_len),
    .lo_thresh(lo_thresh), .meas_q(meas_q), .meas_done(meas_done),
    .gain_code(gain_code)
  );

  task automatic chk(input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // highest k whose scaled threshold is reached
  function automatic int exp_code(longint unsigned lvl, longint unsigned thr,
                                  bit mm);
    for (int k = 7; k >= 1; k--) begin
      if (lvl >= (thr << (mm ? 2 * k : k))) return k;
    end
    return 0;
  endfunction

  // one window; ovr_at = index of sample with over-range (-1 none)
  task automatic run_window(input bit mm, input int n, input int amp,
                            input int ovr_at, input bit put_min,
                            input longint unsigned thr, input bit gaps);
    longint unsigned lvl = 0;
    bit ovr = 0;
    int code;
    mode_mean = mm;
    win_len   = 8'(n - 1);
    lo_thresh = ACC_W'(thr);
    for (int i = 0; i < n; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) begin
        smp_valid = 1'b0;
        smp_data  = 14'($urandom);
        ovr_flag  = 1'b1;              // R2: ignored on idle cycles
        @(negedge clk);
      end
      begin
        int v;
        longint unsigned m;
        v = int'($urandom_range(0, 2 * amp)) - amp;
        if (put_min && i == n / 2) v = -8192;
        smp_valid = 1'b1;
        smp_data  = 14'(v);
        ovr_flag  = (i == ovr_at);
        if (i == ovr_at) ovr = 1;
        m = longint'(v < 0 ? -v : v);
        if (mm) lvl = lvl + m * m;
        else if (m > lvl) lvl = m;
      end
      if (i == n - 1) chk("R5 done low inside window", meas_done, 0);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    ovr_flag  = 1'b0;
    code = ovr ? 7 : exp_code(lvl, thr, mm);
    chk(mm ? "R4 mean result" : "R3 peak result", meas_q, lvl);
    chk("R5 done pulse", meas_done, 1);
    chk(ovr ? "R7 overrange code" : "R6 level code", gain_code, code);
    @(negedge clk);
    chk("R5 done single cycle", meas_done, 0);
    chk("R5 result held", meas_q, lvl);
    chk("R8 code held", gain_code, code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset result", meas_q, 0);
    chk("R1 reset done", meas_done, 0);
    chk("R1 reset code", gain_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: most negative sample, threshold 1000 -> 8192 >= 8000 -> code 3
    run_window(0, 4, 100, -1, 1, 1000, 0);
    // R2: single-sample window in mean mode, with idle cycles
    run_window(1, 1, 3000, -1, 0, 50, 1);
    // R7: over-range on the last sample coincides with window completion
    run_window(0, 5, 2000, 4, 0, 100000, 1);
    // R7: not carried into the next window
    run_window(0, 5, 2000, -1, 0, 100000, 0);
    // R6: zero threshold saturates, low level gives 0
    run_window(0, 3, 500, -1, 0, 0, 0);
    run_window(0, 6, 10, -1, 0, 1000, 0);
    // R4: longest window at full scale
    run_window(1, 256, 8191, -1, 1, 1 << 20, 1);
    // R9: random mix of modes, lengths, thresholds
    for (int w = 0; w < 40; w++) begin
      run_window(1'($urandom_range(0, 1)), int'($urandom_range(1, 40)),
                 int'($urandom_range(1, 8191)),
                 ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 39)) : -1,
                 1'($urandom_range(0, 1)),
                 longint'($urandom_range(0, 1 << 22)), 1'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule